// File: doc/BRIEF.md
# Critical-Word-First Cache Line Filler

This block refills one cache line after a miss. It sits between the miss handler and a memory port that returns one word at a time. Each accepted miss names a line, the word within that line that missed, and one of two fetch orders. In wrapped order the block first requests the missed word from memory. It then requests the other words, wrapping past the end of the line. In linear order it requests the words from index zero upward.

In both orders, the missed word is forwarded to the processor on a one-cycle restart strobe in the cycle it arrives. The processor can therefore resume before the line is complete. Every returned word is written into a line buffer and its bit in a per-word arrival map is set. During the fill, a read to the line being filled hits if its word has already arrived and stalls if it has not. Reads to any other line get neither a hit nor a stall, so the normal cache path keeps serving them. One cycle after the last word is captured, a line-complete pulse is raised with the full line on `line_data`, and the block returns to idle.

The controller has four states. `ST_IDLE` waits for a miss. `ST_FETCH` issues requests and captures responses. `ST_DRAIN` has issued every request and only collects the remaining responses. `ST_DONE` is the one-cycle completion state. The transitions are:
- IDLE→FETCH when a miss is accepted.
- FETCH→DRAIN when the last request is accepted by memory.
- FETCH→DONE or DRAIN→DONE when the last response is captured.
- DONE→IDLE unconditionally.

Top module: `cwf_line_filler`

## Requirements
- R1: After reset the block is idle. `miss_ready` is 1, and `mem_req_valid`, `restart_valid` and `fill_done` are 0.
- R2: When `miss_wrap`=1 at acceptance (wrapped order), the k-th word index requested is (crit + k) mod WORDS, for k = 0..WORDS-1, on line `miss_line`.
- R3: When `miss_wrap`=0 at acceptance (linear order), the word indices are requested in ascending order 0..WORDS-1.
- R4: The order is sampled only when the miss is accepted. Changing `miss_wrap` during a fill does not change the request sequence.
- R5: `restart_valid` is high for exactly one cycle per fill. That cycle is the one in which the response carrying the missed word is presented, and `restart_data` then equals that response's data.
- R6: `fill_done` is high for exactly one cycle, the cycle after the last response is captured. `miss_ready` is 1 again in the following cycle.
- R7: During a fill and in the completion cycle, a read to the filling line asserts `rd_hit` with the stored word on `rd_data` if that word has arrived. Otherwise it asserts `rd_stall`.
- R8: A read to any other line, or any read while idle, asserts neither `rd_hit` nor `rd_stall`.
- R9: While `fill_done` is high, word w of `line_data` (bits w*DATA_W upward) equals the response data for word index w.
- R10: `miss_ready` is 0 from acceptance until the block is idle again. A `miss_valid` held high during that time starts no new fill.
- R11: A response presented while idle raises no restart and is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Miss accepted this cycle when high with miss_valid |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | log2(WORDS) | Word index that missed |
| miss_wrap | input | 1 | 1 = wrapped order, 0 = linear order |
| mem_req_valid | output | 1 | Word read request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | LINE_W | Line address of the request |
| mem_req_word | output | log2(WORDS) | Word index of the request |
| mem_rsp_valid | input | 1 | Response word present (in request order) |
| mem_rsp_data | input | DATA_W | Response word |
| restart_valid | output | 1 | Missed word is available to the processor |
| restart_data | output | DATA_W | The missed word |
| fill_done | output | 1 | Line complete pulse |
| line_data | output | WORDS*DATA_W | Filled line, word w at w*DATA_W |
| rd_valid | input | 1 | Processor read probe |
| rd_line | input | LINE_W | Line of the read |
| rd_word | input | log2(WORDS) | Word index of the read |
| rd_hit | output | 1 | Read served from the filling line |
| rd_stall | output | 1 | Read must wait for its word |
| rd_data | output | DATA_W | Data for a hit |

## Verification
The assertions assume that memory returns exactly one response per accepted request, in request order, and never in the same cycle as the request. They also assume that no response arrives while the block is idle, except where the stray-response check deliberately breaks this assumption and only port behaviour is checked. The bench's memory model follows these rules. It keeps a queue of accepted requests, answers each one after one to three cycles, and throttles `mem_req_ready` on some fills. Reads probe the filling line and a neighbouring line every cycle. `miss_wrap` is toggled during some fills to exercise R4.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } fill_state_e;
endpackage

// File: rtl/cwf_order.sv
module cwf_order #(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS),
    localparam int CNT_W = $clog2(WORDS + 1)
) (
    input  logic             wrap,
    input  logic [IDX_W-1:0] crit,
    input  logic [CNT_W-1:0] step,
    output logic [IDX_W-1:0] idx
);
    // WORDS is a power of two, so the modulo is the natural wrap of IDX_W bits.
    logic [IDX_W-1:0] step_low;
    assign step_low = step[IDX_W-1:0];
    assign idx = wrap ? (crit + step_low) : step_low;
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic                    rd_present,
    output logic [DATA_W-1:0]       rd_word,
    output logic [WORDS-1:0]        arrived,
    output logic [WORDS*DATA_W-1:0] line_flat
);
    logic [DATA_W-1:0] word_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic hit_w;
        assign hit_w = wr_en && (wr_idx == IDX_W'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[w]  <= '0;
                arrived[w] <= 1'b0;
            end else begin
                if (hit_w) begin
                    word_q[w] <= wr_data;
                end
                if (clear) begin
                    arrived[w] <= 1'b0;
                end else if (hit_w) begin
                    arrived[w] <= 1'b1;
                end
            end
        end

        assign line_flat[w*DATA_W +: DATA_W] = word_q[w];
    end

    assign rd_present = arrived[rd_idx];
    assign rd_word    = word_q[rd_idx];

    // R9: a word is never written twice within one fill
    p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |-> !arrived[wr_idx])
        else $error("word index written twice in one fill");
endmodule

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
    import cwf_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int LINE_W = 26,
    localparam int IDX_W = $clog2(WORDS),
    localparam int CNT_W = $clog2(WORDS + 1),
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [IDX_W-1:0]  miss_word,
    input  logic              miss_wrap,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [LINE_W-1:0] mem_req_line,
    output logic [IDX_W-1:0]  mem_req_word,
    input  logic              mem_rsp_valid,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              clear,
    output logic              restart_valid,
    output logic              fill_done,
    output logic              rd_open,
    output logic [LINE_W-1:0] fill_line
);
    fill_state_e state_q, state_d;

    logic [LINE_W-1:0] line_q;
    logic [IDX_W-1:0]  crit_q;
    logic              wrap_q;
    logic [CNT_W-1:0]  iss_q;
    logic [CNT_W-1:0]  rcv_q;
    logic              restart_seen_q;

    logic accept;
    logic req_fire;
    logic rsp_take;
    logic last_req;
    logic last_rsp;

    cwf_order #(.WORDS(WORDS)) i_issue_order (
        .wrap (wrap_q),
        .crit (crit_q),
        .step (iss_q),
        .idx  (mem_req_word)
    );

    cwf_order #(.WORDS(WORDS)) i_recv_order (
        .wrap (wrap_q),
        .crit (crit_q),
        .step (rcv_q),
        .idx  (wr_idx)
    );

    assign accept   = miss_ready && miss_valid;
    assign req_fire = mem_req_valid && mem_req_ready;
    assign rsp_take = mem_rsp_valid && (state_q == ST_FETCH || state_q == ST_DRAIN);
    assign last_req = req_fire && (iss_q == LAST);
    assign last_rsp = rsp_take && (rcv_q == LAST);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_FETCH;
            ST_FETCH: begin
                if (last_rsp)      state_d = ST_DONE;
                else if (last_req) state_d = ST_DRAIN;
            end
            ST_DRAIN: if (last_rsp) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // fill context and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q         <= '0;
            crit_q         <= '0;
            wrap_q         <= 1'b0;
            iss_q          <= '0;
            rcv_q          <= '0;
            restart_seen_q <= 1'b0;
        end else if (accept) begin
            line_q         <= miss_line;
            crit_q         <= miss_word;
            wrap_q         <= miss_wrap;
            iss_q          <= '0;
            rcv_q          <= '0;
            restart_seen_q <= 1'b0;
        end else begin
            if (req_fire)      iss_q          <= iss_q + 1'b1;
            if (rsp_take)      rcv_q          <= rcv_q + 1'b1;
            if (restart_valid) restart_seen_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        miss_ready    = 1'b0;
        mem_req_valid = 1'b0;
        fill_done     = 1'b0;
        rd_open       = 1'b0;
        unique case (state_q)
            ST_IDLE:  miss_ready = 1'b1;
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                rd_open       = 1'b1;
            end
            ST_DRAIN: rd_open = 1'b1;
            ST_DONE: begin
                fill_done = 1'b1;
                rd_open   = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_req_line  = line_q;
    assign wr_en         = rsp_take;
    assign clear         = accept;
    assign restart_valid = rsp_take && (wr_idx == crit_q);
    assign fill_line     = line_q;

    // R2: the first request of a wrapped fill names the missed word
    p_wrap_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && wrap_q && iss_q == '0) |-> (mem_req_word == crit_q))
        else $error("wrapped fill did not start at the missed word");

    // R5: the restart strobe fires once per fill
    p_restart_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> !restart_seen_q)
        else $error("second restart in one fill");

    // R5: by completion, the restart has happened
    p_restart_before_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> restart_seen_q)
        else $error("fill completed without restart");

    // R6: completion is a single pulse followed by idle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (!fill_done && miss_ready))
        else $error("completion pulse malformed");

    // R10: no requests while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> !mem_req_valid)
        else $error("memory request while idle");

    // R10: an accepted miss takes the block out of idle
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !miss_ready)
        else $error("still ready after acceptance");
endmodule

// File: rtl/cwf_line_filler.sv
module cwf_line_filler #(
    parameter int LINE_W = 26,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    output logic                    miss_ready,
    input  logic [LINE_W-1:0]       miss_line,
    input  logic [IDX_W-1:0]        miss_word,
    input  logic                    miss_wrap,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [LINE_W-1:0]       mem_req_line,
    output logic [IDX_W-1:0]        mem_req_word,
    input  logic                    mem_rsp_valid,
    input  logic [DATA_W-1:0]       mem_rsp_data,
    output logic                    restart_valid,
    output logic [DATA_W-1:0]       restart_data,
    output logic                    fill_done,
    output logic [WORDS*DATA_W-1:0] line_data,
    input  logic                    rd_valid,
    input  logic [LINE_W-1:0]       rd_line,
    input  logic [IDX_W-1:0]        rd_word,
    output logic                    rd_hit,
    output logic                    rd_stall,
    output logic [DATA_W-1:0]       rd_data
);
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              clear;
    logic              rd_open;
    logic [LINE_W-1:0] fill_line;
    logic              rd_present;
    logic [WORDS-1:0]  arrived;
    logic              line_match;

    cwf_ctrl #(.WORDS(WORDS), .LINE_W(LINE_W)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_ready    (miss_ready),
        .miss_line     (miss_line),
        .miss_word     (miss_word),
        .miss_wrap     (miss_wrap),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_line  (mem_req_line),
        .mem_req_word  (mem_req_word),
        .mem_rsp_valid (mem_rsp_valid),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .clear         (clear),
        .restart_valid (restart_valid),
        .fill_done     (fill_done),
        .rd_open       (rd_open),
        .fill_line     (fill_line)
    );

    cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) i_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (mem_rsp_data),
        .rd_idx     (rd_word),
        .rd_present (rd_present),
        .rd_word    (rd_data),
        .arrived    (arrived),
        .line_flat  (line_data)
    );

    assign restart_data = mem_rsp_data;
    assign line_match   = rd_valid && rd_open && (rd_line == fill_line);
    assign rd_hit       = line_match && rd_present;
    assign rd_stall     = line_match && !rd_present;

    // R9: completion only with every word present
    p_done_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (&arrived))
        else $error("completion with missing words");

    // R7: hit and stall are exclusive
    p_hit_xor_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hit && rd_stall))
        else $error("hit and stall together");

    // R8: no hit or stall while idle
    p_idle_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> (!rd_hit && !rd_stall))
        else $error("read response while idle");
endmodule

// File: tb/test_cwf_line_filler.sv
`timescale 1ns/1ps
module test_cwf_line_filler;
    localparam int LINE_W = 26;
    localparam int W      = 8;
    localparam int DW     = 32;
    localparam int IW     = $clog2(W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              miss_valid = 0, miss_ready, miss_wrap = 0;
    logic [LINE_W-1:0] miss_line = '0;
    logic [IW-1:0]     miss_word = '0;
    logic              mem_req_valid, mem_req_ready = 1;
    logic [LINE_W-1:0] mem_req_line;
    logic [IW-1:0]     mem_req_word;
    logic              mem_rsp_valid = 0;
    logic [DW-1:0]     mem_rsp_data = '0;
    logic              restart_valid, fill_done;
    logic [DW-1:0]     restart_data;
    logic [W*DW-1:0]   line_data;
    logic              rd_valid = 0, rd_hit, rd_stall;
    logic [LINE_W-1:0] rd_line = '0;
    logic [IW-1:0]     rd_word = '0;
    logic [DW-1:0]     rd_data;

    cwf_line_filler #(.LINE_W(LINE_W), .WORDS(W), .DATA_W(DW)) i_cwf_line_filler (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
        .miss_word(miss_word), .miss_wrap(miss_wrap),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_line(mem_req_line), .mem_req_word(mem_req_word),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .restart_valid(restart_valid), .restart_data(restart_data),
        .fill_done(fill_done), .line_data(line_data),
        .rd_valid(rd_valid), .rd_line(rd_line), .rd_word(rd_word),
        .rd_hit(rd_hit), .rd_stall(rd_stall), .rd_data(rd_data)
    );

    int total = 0, failed = 0, cyc = 0;
    bit finished = 0;

    // reference model state
    bit m_busy = 0, m_done = 0, m_wrap = 0;
    int m_line = 0, m_crit = 0, m_iss = 0, m_rcv = 0;
    bit m_vb [W];
    int q_idx [$];
    int q_time [$];
    int last_time = 0;

    // stimulus knobs
    bit throttle = 0, reads_on = 1, stray = 0;
    int lat_span = 1;

    function automatic int ord(int k, int crit, bit wrap);
        return wrap ? (crit + k) % W : k;
    endfunction

    function automatic logic [DW-1:0] mkdata(int line, int idx);
        return DW'((line * 16 + idx) ^ 32'h5A5A_0000);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // one clock cycle: drive at negedge, check 1 ns later, update model at posedge
    task automatic tick();
        bit e_ready, e_req, rsp_fire, e_restart, req_fire, accept, new_done;
        bit e_hit, e_stall, lm;
        int e_word, ridx;
        string tag;
        rsp_fire = 0;
        ridx = 0;
        mem_req_ready = throttle ? ((cyc % 3) != 1) : 1'b1;
        if (m_busy && q_idx.size() > 0 && q_time[0] <= cyc) begin
            ridx = q_idx[0];
            mem_rsp_valid = 1;
            mem_rsp_data = mkdata(m_line, ridx);
            rsp_fire = 1;
        end else if (stray && !m_busy && !m_done) begin
            mem_rsp_valid = 1;
            mem_rsp_data = 32'hDEAD_BEEF;
        end else begin
            mem_rsp_valid = 0;
            mem_rsp_data = '0;
        end
        rd_valid = reads_on;
        rd_line  = ((cyc % 5) == 0) ? LINE_W'(m_line + 1) : LINE_W'(m_line);
        rd_word  = IW'((cyc * 3) % W);
        #1;
        e_ready = !m_busy && !m_done;
        chk(miss_ready == e_ready, e_ready ? "R1" : "R10", "miss_ready", miss_ready, e_ready);
        chk(fill_done == m_done, "R6", "fill_done", fill_done, m_done);
        e_req = m_busy && m_iss < W;
        chk(mem_req_valid == e_req, "R1", "mem_req_valid", mem_req_valid, e_req);
        if (e_req && mem_req_valid) begin
            e_word = ord(m_iss, m_crit, m_wrap);
            tag = (miss_wrap != m_wrap) ? "R4" : (m_wrap ? "R2" : "R3");
            chk(mem_req_word == IW'(e_word), tag, "mem_req_word", mem_req_word, e_word);
            chk(mem_req_line == LINE_W'(m_line), tag, "mem_req_line", mem_req_line, m_line);
        end
        e_restart = rsp_fire && (ridx == m_crit);
        chk(restart_valid == e_restart, stray ? "R11" : "R5", "restart_valid", restart_valid, e_restart);
        if (e_restart && restart_valid)
            chk(restart_data == mkdata(m_line, m_crit), "R5", "restart_data", restart_data, mkdata(m_line, m_crit));
        if (reads_on) begin
            lm = (m_busy || m_done) && (int'(rd_line) == m_line);
            e_hit = lm && m_vb[int'(rd_word)];
            e_stall = lm && !m_vb[int'(rd_word)];
            chk(rd_hit == e_hit, lm ? "R7" : "R8", "rd_hit", rd_hit, e_hit);
            chk(rd_stall == e_stall, lm ? "R7" : "R8", "rd_stall", rd_stall, e_stall);
            if (e_hit && rd_hit)
                chk(rd_data == mkdata(m_line, int'(rd_word)), "R7", "rd_data", rd_data, mkdata(m_line, int'(rd_word)));
        end
        if (m_done) begin
            for (int w = 0; w < W; w++)
                chk(line_data[w*DW +: DW] == mkdata(m_line, w), "R9", "line_data word", line_data[w*DW +: DW], mkdata(m_line, w));
        end
        req_fire = e_req && mem_req_ready;
        accept = e_ready && miss_valid;
        @(posedge clk);
        new_done = rsp_fire && (m_rcv == W - 1);
        if (rsp_fire) begin
            m_vb[ridx] = 1;
            void'(q_idx.pop_front());
            void'(q_time.pop_front());
            m_rcv++;
            if (new_done) m_busy = 0;
        end
        if (req_fire) begin
            last_time = (cyc + 1 + (cyc % lat_span) > last_time) ? cyc + 1 + (cyc % lat_span) : last_time;
            q_idx.push_back(ord(m_iss, m_crit, m_wrap));
            q_time.push_back(last_time);
            m_iss++;
        end
        m_done = new_done;
        if (accept) begin
            m_busy = 1;
            m_line = int'(miss_line);
            m_crit = int'(miss_word);
            m_wrap = miss_wrap;
            m_iss = 0;
            m_rcv = 0;
            for (int w = 0; w < W; w++) m_vb[w] = 0;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic do_fill(int line, int crit, bit wrap, bit toggle, bit hold);
        int n = 0;
        miss_valid = 1;
        miss_line = LINE_W'(line);
        miss_word = IW'(crit);
        miss_wrap = wrap;
        while (!m_busy && n < 50) begin tick(); n++; end
        if (hold) miss_line = LINE_W'(line + 7);
        else miss_valid = 0;
        while (m_busy || m_done) begin
            if (toggle) miss_wrap = ~miss_wrap;
            tick();
            n++;
            if (n > 400) begin
                chk(0, "R6", "fill never completed", 0, 1);
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  %0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < W; w++) m_vb[w] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state, idle cycles
        chk(miss_ready == 1, "R1", "miss_ready after reset", miss_ready, 1);
        chk(restart_valid == 0, "R1", "restart after reset", restart_valid, 0);
        repeat (3) tick();
        // R2 wrapped fills, middle / first / last critical word
        do_fill(100, 5, 1, 0, 0);
        do_fill(101, 0, 1, 0, 0);
        lat_span = 3;
        do_fill(102, W - 1, 1, 0, 0);
        // R3 linear fills, throttled port
        throttle = 1;
        do_fill(200, 6, 0, 0, 0);
        do_fill(201, 0, 0, 0, 0);
        do_fill(202, W - 1, 0, 0, 0);
        // R4 mode input toggled mid-fill
        do_fill(300, 3, 1, 1, 0);
        do_fill(301, 2, 0, 1, 0);
        // R11 stray responses while idle
        stray = 1;
        repeat (3) tick();
        stray = 0;
        // R10 miss_valid held high through a fill, next fill starts after completion
        throttle = 0;
        do_fill(400, 4, 1, 0, 1);
        do_fill(407, 4, 1, 0, 0);
        repeat (3) tick();
        finished = 1;
        $display("  %0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule